// File: doc/BRIEF.md
# Task Dependency Resolution Unit

This block tracks data hazards between tasks that software hands it in program order. Each task record carries a task id and up to `NOPS` operand addresses, and each operand is marked as read or written. The unit hashes every operand address to a slot and makes the task wait on earlier pending tasks that touch the same address. Once nothing is left to wait on, the task id goes into a FIFO ready queue. Workers pull ids from that queue. When a worker finishes a task, it returns the id on the completion port. The unit then releases the tasks waiting on that id and frees the task's table entries.

Each slot holds the resident address and an ordered subscriber list of pending accesses, each an id plus a read/write flag. A write entry in the list marks the start of a new generation: readers wait on the newest writer before them, and a writer waits on the readers since the previous writer, or on that writer if there were no readers. A new task only counts its dependencies when it is inserted. On completion the unit walks the affected lists one subscriber per cycle and decrements the waiting tasks' counts. Every structure has a fixed size, and insertion stalls when a structure cannot take more. Completion work takes the shared tables ahead of insertion. The operands of one task must land in distinct slots, and only ids that the ready queue has delivered may be reported as finished.

Top module: `task_dep_unit`

## Requirements
- R1: After reset, `add_ready_o` and `fin_ready_o` are 1 and `rdy_valid_o` is 0.
- R2: Tasks with no pending conflicts leave the ready queue in the order their records were accepted, and each accepted record yields its id exactly once.
- R3: A task that reads an address written by a pending earlier task stays out of the ready queue until that writer is reported finished.
- R4: A task that writes an address read by pending earlier tasks becomes ready only after all of those readers are reported finished.
- R5: Writers of one address are serialized. A reader between two writers waits for the first writer. The second writer waits for that reader. A reader after the second writer waits for the second writer.
- R6: A task's wait spans all of its operands: it becomes ready only when the last of its predecessors, over every operand, is reported finished.
- R7: An operand's slot is the XOR fold of its address, in which address bit i toggles slot bit (i mod `SLOT_W`). If the slot is held by a different address, insertion stalls with `add_ready_o` at 0 until that slot empties.
- R8: A record whose id is still pending waits until that id is reported finished and freed, and it is then processed normally.
- R9: A slot holds at most `LIST_D` pending accesses. A further access to that address stalls insertion until one of them is freed.
- R10: While `rdy_valid_o` is 1 and `rdy_ready_i` is 0, `rdy_id_o` holds its value. When the queue is full, a task that finishes insertion with nothing to wait on stalls the add port.
- R11: The add port takes one record per handshake and drops `add_ready_o` in the next cycle. Operand k is enabled by bit k of `add_use_i`, is a write when bit k of `add_wr_i` is 1, and takes its address from bits [k*AW +: AW] of `add_addr_i`.
- R12: The completion port takes one id per handshake and drops `fin_ready_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_valid_i | input | 1 | New task record offered |
| add_ready_o | output | 1 | Record buffer empty |
| add_id_i | input | ID_W | Task id of the record |
| add_use_i | input | NOPS | Operand enable per operand |
| add_wr_i | input | NOPS | Operand is written (1) or read (0) |
| add_addr_i | input | NOPS*AW | Operand addresses, operand k at [k*AW +: AW] |
| fin_valid_i | input | 1 | Finished task id offered |
| fin_ready_o | output | 1 | Completion path idle |
| fin_id_i | input | ID_W | Id of the finished task |
| rdy_valid_o | output | 1 | Ready queue not empty |
| rdy_ready_i | input | 1 | Consumer takes the head id |
| rdy_id_o | output | ID_W | Id at the head of the ready queue |

## Verification
The assertions check the port-level rules on every cycle. After each handshake the add and completion ports drop ready. A held ready-queue head keeps its id. No id leaves the queue unless more records have been accepted than ids delivered. Hazard ordering cannot be checked that way: the read-after-write, write-after-read and write-after-write cases, the multi-operand counts, the hash collision, the full list, the reuse of a pending id and the full ready queue each show up only in a directed scenario. In those scenarios the bench completes tasks in a chosen order and compares the set of ids released after each completion with the expected set.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  typedef enum logic [1:0] {TS_FREE, TS_FILL, TS_WAIT, TS_RUN} task_st_e;
  typedef enum logic [1:0] {A_IDLE, A_CLAIM, A_OP, A_DONE} add_st_e;
  typedef enum logic [1:0] {F_IDLE, F_OP, F_WALK, F_DEL} fin_st_e;
endpackage

// File: rtl/tdu_hash.sv
module tdu_hash #(
  parameter int AW     = 16,
  parameter int SLOT_W = 3
) (
  input  logic [AW-1:0]     addr_i,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    slot_o = '0;
    for (int i = 0; i < AW; i++) slot_o[i % SLOT_W] = slot_o[i % SLOT_W] ^ addr_i[i];
  end
endmodule

// File: rtl/tdu_ready_fifo.sv
module tdu_ready_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == FULL);
  assign valid_o = (cnt != '0);
  assign dout_o  = mem[rp];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din_i;
        wp      <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/task_dep_unit.sv
module task_dep_unit
  import tdu_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int NOPS   = 4,
  parameter int AW     = 16,
  parameter int SLOT_W = 3,
  parameter int LIST_D = 8,
  parameter int RQ_D   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               add_valid_i,
  output logic               add_ready_o,
  input  logic [ID_W-1:0]    add_id_i,
  input  logic [NOPS-1:0]    add_use_i,
  input  logic [NOPS-1:0]    add_wr_i,
  input  logic [NOPS*AW-1:0] add_addr_i,
  input  logic               fin_valid_i,
  output logic               fin_ready_o,
  input  logic [ID_W-1:0]    fin_id_i,
  output logic               rdy_valid_o,
  input  logic               rdy_ready_i,
  output logic [ID_W-1:0]    rdy_id_o
);
  localparam int NT  = 1 << ID_W;
  localparam int NS  = 1 << SLOT_W;
  localparam int LW  = $clog2(LIST_D + 1);
  localparam int PW  = $clog2(LIST_D);
  localparam int CW  = $clog2(NOPS * LIST_D + 1);
  localparam int OW  = $clog2(NOPS + 1);
  localparam int OPW = (NOPS > 1) ? $clog2(NOPS) : 1;
  localparam logic [OW-1:0] OP_END   = OW'(NOPS);
  localparam logic [LW-1:0] FULL_LEN = LW'(LIST_D);

  // task table
  task_st_e          t_st   [NT];
  logic [CW-1:0]     t_cnt  [NT];
  logic [NOPS-1:0]   t_use  [NT];
  logic [SLOT_W-1:0] t_slot [NT][NOPS];

  // slot table: resident address and ordered subscriber list
  logic [AW-1:0]     s_addr [NS];
  logic [LW-1:0]     s_len  [NS];
  logic [ID_W-1:0]   s_id   [NS][LIST_D];
  logic              s_wr   [NS][LIST_D];

  // add path
  add_st_e           a_state;
  logic [ID_W-1:0]   a_id;
  logic [NOPS-1:0]   a_use, a_wr;
  logic [AW-1:0]     a_addr [NOPS];
  logic [OW-1:0]     a_op;
  logic [OPW-1:0]    a_ix;
  logic [AW-1:0]     cur_addr;
  logic [SLOT_W-1:0] cur_slot;
  logic [LW-1:0]     cur_len;
  logic              sc_wr_seen, a_can, add_go, a_push;
  logic [CW-1:0]     sc_rd_n, a_deps;

  // finish path
  fin_st_e           f_state;
  logic [ID_W-1:0]   f_id;
  logic [OW-1:0]     f_op;
  logic [OPW-1:0]    f_ix;
  logic [PW-1:0]     f_pos, f_fnd;
  logic [LW-1:0]     f_p, f_len;
  logic              f_wr, f_seen, f_in, e_wr;
  logic [SLOT_W-1:0] f_slot;
  logic [ID_W-1:0]   e_id;
  logic [CW-1:0]     f_nc;
  logic              f_dec, f_push_want, f_hold, f_push;

  // ready queue
  logic              rq_full, rq_push;
  logic [ID_W-1:0]   rq_din;

  assign add_ready_o = (a_state == A_IDLE);
  assign fin_ready_o = (f_state == F_IDLE);
  assign add_go      = (f_state == F_IDLE) && !fin_valid_i;

  assign a_ix     = a_op[OPW-1:0];
  assign cur_addr = a_addr[a_ix];

  tdu_hash #(.AW(AW), .SLOT_W(SLOT_W)) i_hash (
    .addr_i (cur_addr),
    .slot_o (cur_slot)
  );

  assign cur_len = s_len[cur_slot];

  // scan the target list: newest writer present, readers queued after it
  always_comb begin
    sc_wr_seen = 1'b0;
    sc_rd_n    = '0;
    for (int p = 0; p < LIST_D; p++) begin
      if (LW'(p) < cur_len) begin
        if (s_wr[cur_slot][p]) begin
          sc_wr_seen = 1'b1;
          sc_rd_n    = '0;
        end else begin
          sc_rd_n = sc_rd_n + 1'b1;
        end
      end
    end
    if (!a_wr[a_ix])        a_deps = sc_wr_seen ? CW'(1) : '0;
    else if (sc_rd_n != '0) a_deps = sc_rd_n;
    else                    a_deps = sc_wr_seen ? CW'(1) : '0;
  end

  assign a_can  = !((cur_len != '0) && (s_addr[cur_slot] != cur_addr)) && (cur_len != FULL_LEN);
  assign a_push = (a_state == A_DONE) && add_go && (t_cnt[a_id] == '0) && !rq_full;

  assign f_ix   = f_op[OPW-1:0];
  assign f_slot = t_slot[f_id][f_ix];
  assign f_len  = s_len[f_slot];

  always_comb begin
    f_fnd = '0;
    for (int p = 0; p < LIST_D; p++)
      if ((LW'(p) < f_len) && (s_id[f_slot][p] == f_id)) f_fnd = PW'(p);
  end

  assign f_in  = (f_p < f_len);
  assign e_id  = s_id[f_slot][f_p[PW-1:0]];
  assign e_wr  = s_wr[f_slot][f_p[PW-1:0]];
  // finished writer releases following readers, or the next writer if none; reader releases next writer
  assign f_dec = (f_state == F_WALK) && f_in && (f_wr ? (!e_wr || !f_seen) : e_wr);
  assign f_nc  = t_cnt[e_id] - 1'b1;
  assign f_push_want = f_dec && (f_nc == '0) && (t_st[e_id] == TS_WAIT);
  assign f_hold = f_push_want && rq_full;
  assign f_push = f_push_want && !rq_full;

  assign rq_push = a_push || f_push;
  assign rq_din  = a_push ? a_id : e_id;

  tdu_ready_fifo #(.W(ID_W), .DEPTH(RQ_D)) i_rq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rq_push),
    .din_i   (rq_din),
    .full_o  (rq_full),
    .pop_i   (rdy_ready_i),
    .valid_o (rdy_valid_o),
    .dout_o  (rdy_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_state <= A_IDLE;
      a_id    <= '0;
      a_use   <= '0;
      a_wr    <= '0;
      a_op    <= '0;
      f_state <= F_IDLE;
      f_id    <= '0;
      f_op    <= '0;
      f_pos   <= '0;
      f_p     <= '0;
      f_wr    <= 1'b0;
      f_seen  <= 1'b0;
      for (int k = 0; k < NOPS; k++) a_addr[k] <= '0;
      for (int i = 0; i < NT; i++) begin
        t_st[i]  <= TS_FREE;
        t_cnt[i] <= '0;
        t_use[i] <= '0;
        for (int k = 0; k < NOPS; k++) t_slot[i][k] <= '0;
      end
      for (int s = 0; s < NS; s++) begin
        s_addr[s] <= '0;
        s_len[s]  <= '0;
        for (int p = 0; p < LIST_D; p++) begin
          s_id[s][p] <= '0;
          s_wr[s][p] <= 1'b0;
        end
      end
    end else begin
      // ---------------- add path ----------------
      case (a_state)
        A_IDLE: if (add_valid_i) begin
          a_id  <= add_id_i;
          a_use <= add_use_i;
          a_wr  <= add_wr_i;
          for (int k = 0; k < NOPS; k++) a_addr[k] <= add_addr_i[k*AW +: AW];
          a_state <= A_CLAIM;
        end
        A_CLAIM: if (add_go && (t_st[a_id] == TS_FREE)) begin
          t_st[a_id]  <= TS_FILL;
          t_cnt[a_id] <= '0;
          t_use[a_id] <= a_use;
          a_op        <= '0;
          a_state     <= A_OP;
        end
        A_OP: if (add_go) begin
          if (a_op == OP_END) begin
            a_state <= A_DONE;
          end else if (!a_use[a_ix]) begin
            a_op <= a_op + 1'b1;
          end else if (a_can) begin
            s_id[cur_slot][cur_len[PW-1:0]] <= a_id;
            s_wr[cur_slot][cur_len[PW-1:0]] <= a_wr[a_ix];
            s_len[cur_slot]     <= cur_len + 1'b1;
            s_addr[cur_slot]    <= cur_addr;
            t_cnt[a_id]         <= t_cnt[a_id] + a_deps;
            t_slot[a_id][a_ix]  <= cur_slot;
            a_op                <= a_op + 1'b1;
          end
        end
        A_DONE: if (add_go) begin
          if (t_cnt[a_id] != '0) begin
            t_st[a_id] <= TS_WAIT;
            a_state    <= A_IDLE;
          end else if (a_push) begin
            t_st[a_id] <= TS_RUN;
            a_state    <= A_IDLE;
          end
        end
        default: a_state <= A_IDLE;
      endcase

      // ---------------- finish path ----------------
      case (f_state)
        F_IDLE: if (fin_valid_i) begin
          f_id    <= fin_id_i;
          f_op    <= '0;
          f_state <= F_OP;
        end
        F_OP: begin
          if (f_op == OP_END) begin
            t_st[f_id] <= TS_FREE;
            f_state    <= F_IDLE;
          end else if (!t_use[f_id][f_ix]) begin
            f_op <= f_op + 1'b1;
          end else begin
            f_pos   <= f_fnd;
            f_wr    <= s_wr[f_slot][f_fnd];
            f_p     <= LW'(f_fnd) + 1'b1;
            f_seen  <= 1'b0;
            f_state <= F_WALK;
          end
        end
        F_WALK: if (!f_in) begin
          f_state <= F_DEL;
        end else if (!f_hold) begin
          if (f_dec) t_cnt[e_id] <= f_nc;
          if (f_push) t_st[e_id] <= TS_RUN;
          if (!e_wr) f_seen <= 1'b1;
          if (e_wr) f_state <= F_DEL;
          else      f_p <= f_p + 1'b1;
        end
        F_DEL: begin
          for (int p = 0; p < LIST_D - 1; p++) begin
            if (PW'(p) >= f_pos) begin
              s_id[f_slot][p] <= s_id[f_slot][p+1];
              s_wr[f_slot][p] <= s_wr[f_slot][p+1];
            end
          end
          s_len[f_slot] <= f_len - 1'b1;
          f_op    <= f_op + 1'b1;
          f_state <= F_OP;
        end
        default: f_state <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdu_chk.sv
module tdu_chk #(
  parameter int ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            add_valid_i,
  input logic            add_ready_o,
  input logic            fin_valid_i,
  input logic            fin_ready_o,
  input logic            rdy_valid_o,
  input logic            rdy_ready_i,
  input logic [ID_W-1:0] rdy_id_o
);
  logic [15:0] outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding <= '0;
    else outstanding <= outstanding + {15'd0, add_valid_i && add_ready_o}
                                    - {15'd0, rdy_valid_o && rdy_ready_i};
  end

  // R11
  add_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_valid_i && add_ready_o |=> !add_ready_o);

  // R12
  fin_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_i && fin_ready_o |=> !fin_ready_o);

  // R10
  rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o && !rdy_ready_i |=> rdy_valid_o && $stable(rdy_id_o));

  // R2
  rdy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o |-> outstanding != '0);
endmodule

bind task_dep_unit tdu_chk #(.ID_W(ID_W)) i_tdu_chk (.*);

// File: tb/test_task_dep_unit.sv
module test_task_dep_unit;
  localparam int ID_W = 4;
  localparam int NOPS = 4;
  localparam int AW   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              add_valid = 1'b0;
  logic              add_ready;
  logic [ID_W-1:0]   add_id = '0;
  logic [NOPS-1:0]   add_use = '0, add_wr = '0;
  logic [NOPS*AW-1:0] add_addr = '0;
  logic              fin_valid = 1'b0;
  logic              fin_ready;
  logic [ID_W-1:0]   fin_id = '0;
  logic              rdy_valid;
  logic              rdy_ready = 1'b1;
  logic [ID_W-1:0]   rdy_id;

  int n_chk = 0, n_err = 0;
  int pop_mask = 0, pop_n = 0;
  int pop_log [32];
  bit done = 0;

  always #10 clk = ~clk;

  task_dep_unit i_task_dep_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .add_valid_i(add_valid), .add_ready_o(add_ready), .add_id_i(add_id),
    .add_use_i(add_use), .add_wr_i(add_wr), .add_addr_i(add_addr),
    .fin_valid_i(fin_valid), .fin_ready_o(fin_ready), .fin_id_i(fin_id),
    .rdy_valid_o(rdy_valid), .rdy_ready_i(rdy_ready), .rdy_id_o(rdy_id)
  );

  always @(posedge clk) begin
    if (rst_n && rdy_valid && rdy_ready) begin
      pop_mask = pop_mask | (1 << rdy_id);
      if (pop_n < 32) pop_log[pop_n] = int'(rdy_id);
      pop_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic expect_mask(input int exp, input string req);
    settle();
    chk(pop_mask == exp, req, pop_mask, exp);
    pop_mask = 0;
    pop_n = 0;
  endtask

  task automatic add_task(input int id, input logic [3:0] use_m, input logic [3:0] wr_m,
                          input int a0, input int a1, input int a2, input int a3);
    @(negedge clk);
    while (!add_ready) @(negedge clk);
    add_valid = 1'b1;
    add_id    = ID_W'(id);
    add_use   = use_m;
    add_wr    = wr_m;
    add_addr  = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    @(negedge clk);
    add_valid = 1'b0;
    chk(add_ready == 1'b0, "R11 add_ready after accept", int'(add_ready), 0);
  endtask

  task automatic finish(input int id);
    @(negedge clk);
    while (!fin_ready) @(negedge clk);
    fin_valid = 1'b1;
    fin_id    = ID_W'(id);
    @(negedge clk);
    fin_valid = 1'b0;
    chk(fin_ready == 1'b0, "R12 fin_ready after accept", int'(fin_ready), 0);
  endtask

  task automatic t_reset();
    chk(add_ready == 1'b1, "R1 add_ready", int'(add_ready), 1);
    chk(fin_ready == 1'b1, "R1 fin_ready", int'(fin_ready), 1);
    chk(rdy_valid == 1'b0, "R1 rdy_valid", int'(rdy_valid), 0);
  endtask

  task automatic t_indep();
    add_task(5, 4'b0001, 4'b0001, 1, 0, 0, 0);
    add_task(2, 4'b0001, 4'b0000, 2, 0, 0, 0);
    add_task(9, 4'b0001, 4'b0001, 3, 0, 0, 0);
    settle();
    chk(pop_n == 3, "R2 count", pop_n, 3);
    chk(pop_log[0] == 5, "R2 order 0", pop_log[0], 5);
    chk(pop_log[1] == 2, "R2 order 1", pop_log[1], 2);
    chk(pop_log[2] == 9, "R2 order 2", pop_log[2], 9);
    pop_mask = 0; pop_n = 0;
    finish(5); finish(2); finish(9);
    expect_mask(0, "R2 nothing after finishes");
  endtask

  task automatic t_raw();
    add_task(0, 4'b0001, 4'b0001, 4, 0, 0, 0);
    add_task(1, 4'b0001, 4'b0000, 4, 0, 0, 0);
    expect_mask(32'h1, "R3 reader held");
    finish(0);
    expect_mask(32'h2, "R3 reader released");
    finish(1);
    expect_mask(0, "R3 idle");
  endtask

  task automatic t_war();
    add_task(0, 4'b0001, 4'b0000, 5, 0, 0, 0);
    add_task(1, 4'b0001, 4'b0000, 5, 0, 0, 0);
    add_task(2, 4'b0001, 4'b0001, 5, 0, 0, 0);
    expect_mask(32'h3, "R4 readers ready writer held");
    finish(0);
    expect_mask(0, "R4 one reader left");
    finish(1);
    expect_mask(32'h4, "R4 writer released");
    finish(2);
    expect_mask(0, "R4 idle");
  endtask

  task automatic t_waw();
    add_task(0, 4'b0001, 4'b0001, 6, 0, 0, 0);
    add_task(1, 4'b0001, 4'b0000, 6, 0, 0, 0);
    add_task(2, 4'b0001, 4'b0001, 6, 0, 0, 0);
    add_task(3, 4'b0001, 4'b0000, 6, 0, 0, 0);
    expect_mask(32'h1, "R5 first writer only");
    finish(0);
    expect_mask(32'h2, "R5 middle reader");
    finish(1);
    expect_mask(32'h4, "R5 second writer");
    finish(2);
    expect_mask(32'h8, "R5 last reader");
    finish(3);
    expect_mask(0, "R5 idle");
  endtask

  task automatic t_multi();
    add_task(0, 4'b0001, 4'b0001, 1, 0, 0, 0);
    add_task(1, 4'b0001, 4'b0001, 2, 0, 0, 0);
    add_task(4, 4'b1010, 4'b0000, 0, 1, 0, 2);
    expect_mask(32'h3, "R6 producers ready");
    finish(0);
    expect_mask(0, "R6 one operand pending");
    finish(1);
    expect_mask(32'h10, "R6 all operands clear");
    finish(4);
    expect_mask(0, "R6 idle");
  endtask

  task automatic t_collide();
    add_task(0, 4'b0001, 4'b0001, 1, 0, 0, 0);
    add_task(1, 4'b0001, 4'b0000, 8, 0, 0, 0);
    expect_mask(32'h1, "R7 colliding task held");
    chk(add_ready == 1'b0, "R7 add stalled", int'(add_ready), 0);
    finish(0);
    expect_mask(32'h2, "R7 inserted after free");
    chk(add_ready == 1'b1, "R7 add resumed", int'(add_ready), 1);
    finish(1);
    expect_mask(0, "R7 idle");
  endtask

  task automatic t_reuse();
    add_task(0, 4'b0001, 4'b0000, 2, 0, 0, 0);
    add_task(0, 4'b0001, 4'b0000, 3, 0, 0, 0);
    expect_mask(32'h1, "R8 first instance");
    chk(add_ready == 1'b0, "R8 reuse stalled", int'(add_ready), 0);
    finish(0);
    expect_mask(32'h1, "R8 second instance");
    finish(0);
    expect_mask(0, "R8 idle");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) add_task(i, 4'b0001, 4'b0000, 7, 0, 0, 0);
    add_task(8, 4'b0001, 4'b0000, 7, 0, 0, 0);
    expect_mask(32'hFF, "R9 list filled");
    chk(add_ready == 1'b0, "R9 add stalled", int'(add_ready), 0);
    finish(0);
    expect_mask(32'h100, "R9 entry freed");
    for (int i = 1; i < 9; i++) finish(i);
    expect_mask(0, "R9 idle");
  endtask

  task automatic t_backpressure();
    rdy_ready = 1'b0;
    for (int i = 0; i < 5; i++) add_task(i, 4'b0001, 4'b0000, i + 1, 0, 0, 0);
    settle();
    chk(add_ready == 1'b0, "R10 add stalled on full queue", int'(add_ready), 0);
    chk(rdy_valid == 1'b1, "R10 head valid", int'(rdy_valid), 1);
    chk(rdy_id == 4'd0, "R10 head held", int'(rdy_id), 0);
    rdy_ready = 1'b1;
    settle();
    chk(pop_n == 5, "R10 drained", pop_n, 5);
    for (int i = 0; i < 5; i++) chk(pop_log[i] == i, "R10 order", pop_log[i], i);
    pop_mask = 0; pop_n = 0;
    for (int i = 0; i < 5; i++) finish(i);
    expect_mask(0, "R10 idle");
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_indep();
    t_raw();
    t_war();
    t_waw();
    t_multi();
    t_collide();
    t_reuse();
    t_overflow();
    t_backpressure();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule